// File: doc/BRIEF.md
# Preamble Sync Detector

This block sits behind an FSK demodulator that delivers one hard-decision bit per symbol strobe. Its job is to find the repeated preamble that opens every message and to set byte framing from it. Each accepted bit enters a 32-bit history window. The window is compared against four back-to-back copies of the preamble byte 0xAB, with each byte serialized least significant bit first. When the window matches, the block locks. From that point it assembles every eight accepted bits into a byte and presents the byte with a one-cycle valid strobe.

Two states control the block. In `ST_SEARCH` the window is scanned on every accepted bit, and no bytes are produced. Transition ACQUIRE moves `ST_SEARCH` to `ST_LOCKED` when the window matches. It clears the bit counter, so the next accepted bit becomes bit 0 of the first byte, and it raises a one-cycle sync pulse. In `ST_LOCKED` bytes are framed continuously. Transition RELEASE moves `ST_LOCKED` back to `ST_SEARCH` when the downstream parser requests it through `drop_lock`. Reset is the only other way out of `ST_LOCKED`.

A parameter lets the match accept a small number of mismatched bit positions, so a preamble hit by channel errors can still be acquired. The default accepts none.

Top module: `preamble_sync_detector`

## Requirements
- R1: While `rst` is high at a rising clock edge, `locked`, `sync_pulse` and `byte_vld` are 0 after that edge. The count of window bits is cleared, so no match can occur until 32 bits have been accepted after reset.
- R2: The window holds the last 32 accepted bits, with the earliest in bit 0. In `ST_SEARCH`, the accepted bit that makes the window equal 32'hABABABAB causes the next edge to set `locked` and raise `sync_pulse` for exactly one cycle. Each byte arrives as 1,1,0,1,0,1,0,1. `locked` stays 0 before that bit.
- R3: A match is declared when the number of differing window positions is at most `MAX_ERR`. With `MAX_ERR`=0 a single flipped bit prevents acquisition. With `MAX_ERR`=1 a single flip is accepted and two flips are not.
- R4: While locked, every eighth accepted bit after acquisition produces `byte_vld` high for one cycle, starting at the edge that accepts that bit. `byte_data` carries the first bit of the group in bit 0 and the last in bit 7. Other accepted bits leave `byte_vld` low.
- R5: Cycles with `bit_vld` low are ignored. They do not shift the window, do not advance the framing counter, and produce no `byte_vld` or `sync_pulse` on the next edge.
- R6: While locked, further preamble matches do not raise `sync_pulse` and do not reset the byte framing. `locked` stays 1 unless `drop_lock` is asserted.
- R7: `drop_lock` high in `ST_LOCKED` clears `locked` on the next edge, and the bit offered in that cycle is not framed, so no byte completes. In `ST_SEARCH`, `drop_lock` has no effect, and a match still acquires lock.
- R8: `byte_vld` is never raised while the block is in `ST_SEARCH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Demodulated hard-decision bit |
| drop_lock | input | 1 | Request to return from lock to search |
| sync_pulse | output | 1 | One-cycle pulse on acquisition |
| locked | output | 1 | High while in `ST_LOCKED` |
| byte_data | output | BYTE_W | Last assembled byte, first bit received in bit 0 |
| byte_vld | output | 1 | One-cycle strobe for `byte_data` |

## Verification
The bench builds two instances that share one input stream. The first uses the default `MAX_ERR`=0 and carries every framing, idle, relock and drop scenario. The second uses `MAX_ERR`=1. With the pair, a preamble carrying one flipped bit is shown to be rejected by the strict copy and accepted by the tolerant one, and a preamble with two flips is shown to be rejected by both. All other parameters stay at their defaults (8-bit bytes, four repetitions of 0xAB), which keeps the unique 8-bit alignment of the pattern inside every scenario.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } psd_state_e;

endpackage

// File: rtl/psd_window.sv
// Sliding history of accepted bits with a tolerant pattern compare.
module psd_window #(
    parameter int              WIN_W   = 32,
    parameter int              MAX_ERR = 0,
    parameter logic [WIN_W-1:0] PATTERN = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic bit_in,
    output logic hit
);
    localparam int                 CNT_W     = $clog2(WIN_W + 1);
    localparam logic [CNT_W-1:0]   FILL_LAST = CNT_W'(WIN_W - 1);
    localparam logic [CNT_W-1:0]   ERR_LIM   = CNT_W'(MAX_ERR);

    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] win_d;
    logic [WIN_W-1:0] diff;
    logic [CNT_W-1:0] fill_q;
    logic [CNT_W-1:0] err_cnt;

    // newest bit enters at the top; the oldest sits in bit 0
    assign win_d = {bit_in, win_q[WIN_W-1:1]};
    assign diff  = win_d ^ PATTERN;

    always_comb begin
        err_cnt = '0;
        for (int i = 0; i < WIN_W; i++) begin
            err_cnt = err_cnt + CNT_W'(diff[i]);
        end
    end

    assign hit = shift_en && (fill_q >= FILL_LAST) && (err_cnt <= ERR_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (shift_en) begin
            win_q <= win_d;
            if (fill_q <= FILL_LAST) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/psd_framer.sv
// Groups accepted bits into bytes, first bit in the least significant position.
module psd_framer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              advance,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_vld
);
    localparam int               CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sr_q;
    logic [BYTE_W-1:0] sr_d;

    assign sr_d = {bit_in, sr_q[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            sr_q      <= '0;
            byte_data <= '0;
            byte_vld  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (clear) begin
                cnt_q <= '0;
            end else if (advance) begin
                sr_q <= sr_d;
                if (cnt_q == LAST) begin
                    cnt_q     <= '0;
                    byte_data <= sr_d;
                    byte_vld  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/preamble_sync_detector.sv
module preamble_sync_detector #(
    parameter int                BYTE_W    = 8,
    parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'hAB,
    parameter int                NUM_REPS  = 4,
    parameter int                MAX_ERR   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              drop_lock,
    output logic              sync_pulse,
    output logic              locked,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_vld
);
    import psd_pkg::*;

    localparam int               WIN_W   = BYTE_W * NUM_REPS;
    localparam logic [WIN_W-1:0] PATTERN = {NUM_REPS{SYNC_BYTE}};

    psd_state_e state_q;
    psd_state_e state_d;
    logic       hit;
    logic       acquire;
    logic       frame_adv;

    psd_window #(
        .WIN_W   (WIN_W),
        .MAX_ERR (MAX_ERR),
        .PATTERN (PATTERN)
    ) i_window (
        .clk      (clk),
        .rst      (rst),
        .shift_en (bit_vld),
        .bit_in   (bit_in),
        .hit      (hit)
    );

    assign acquire   = (state_q == ST_SEARCH) && hit;
    assign frame_adv = (state_q == ST_LOCKED) && bit_vld && !drop_lock;

    psd_framer #(
        .BYTE_W (BYTE_W)
    ) i_framer (
        .clk       (clk),
        .rst       (rst),
        .clear     (acquire),
        .advance   (frame_adv),
        .bit_in    (bit_in),
        .byte_data (byte_data),
        .byte_vld  (byte_vld)
    );

    // transitions: ACQUIRE (search -> locked), RELEASE (locked -> search)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEARCH: if (hit)       state_d = ST_LOCKED;
            ST_LOCKED: if (drop_lock) state_d = ST_SEARCH;
            default:                  state_d = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SEARCH;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) sync_pulse <= 1'b0;
        else     sync_pulse <= acquire;
    end

    assign locked = (state_q == ST_LOCKED);

endmodule

// File: rtl/psd_checker.sv
module psd_checker (
    input logic clk,
    input logic rst,
    input logic bit_vld,
    input logic drop_lock,
    input logic sync_pulse,
    input logic locked,
    input logic byte_vld
);
    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> !sync_pulse); // R2
    AST_SYNC_WITH_LOCK: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> locked); // R2
    AST_LOCK_RISE_SYNC: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> sync_pulse); // R2
    AST_SYNC_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> !$past(locked)); // R6
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        locked && !drop_lock |=> locked); // R6
    AST_BYTE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> !byte_vld && !sync_pulse); // R5
    AST_DROP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        locked && drop_lock |=> !locked && !byte_vld); // R7
    AST_BYTE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> locked); // R8
endmodule

bind preamble_sync_detector psd_checker i_psd_checker (
    .clk        (clk),
    .rst        (rst),
    .bit_vld    (bit_vld),
    .drop_lock  (drop_lock),
    .sync_pulse (sync_pulse),
    .locked     (locked),
    .byte_vld   (byte_vld)
);

// File: tb/test_preamble_sync_detector.sv
module test_preamble_sync_detector;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       drop_lock = 1'b0;
    logic       sync_pulse, locked, byte_vld;
    logic [7:0] byte_data;
    logic       sync_t, locked_t, byte_vld_t;
    logic [7:0] byte_data_t;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench reference framing
    bit         ref_locked = 1'b0;
    int         ref_cnt = 0;
    logic [7:0] ref_sr = '0;

    localparam logic [31:0] PRE = 32'hABABABAB;

    always #2 clk = ~clk;

    preamble_sync_detector i_preamble_sync_detector (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .drop_lock(drop_lock),
        .sync_pulse(sync_pulse), .locked(locked), .byte_data(byte_data), .byte_vld(byte_vld)
    );

    preamble_sync_detector #(.MAX_ERR(1)) i_tol (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .drop_lock(drop_lock),
        .sync_pulse(sync_t), .locked(locked_t), .byte_data(byte_data_t), .byte_vld(byte_vld_t)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_vld = 1'b0; drop_lock = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(locked == 1'b0 && sync_pulse == 1'b0 && byte_vld == 1'b0, "R1", "outputs in reset",
            {locked, sync_pulse, byte_vld}, 0);
        @(negedge clk);
        rst = 1'b0;
        ref_locked = 1'b0; ref_cnt = 0; ref_sr = '0;
    endtask

    // one accepted bit, outputs checked after the edge that takes it
    task automatic push(input logic b);
        @(negedge clk);
        bit_vld = 1'b1; bit_in = b;
        @(posedge clk);
        #1;
        if (ref_locked) begin
            chk(locked == 1'b1 && sync_pulse == 1'b0, "R6", "lock held, no sync",
                {locked, sync_pulse}, 2);
            ref_sr = {b, ref_sr[7:1]};
            ref_cnt++;
            if (ref_cnt == 8) begin
                ref_cnt = 0;
                chk(byte_vld == 1'b1 && byte_data == ref_sr, "R4", "byte strobe/data",
                    {byte_vld, byte_data}, {1'b1, ref_sr});
            end else begin
                chk(byte_vld == 1'b0, "R4", "no strobe mid byte", byte_vld, 0);
            end
        end else begin
            chk(byte_vld == 1'b0, "R8", "no byte while searching", byte_vld, 0);
        end
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) push(v[i]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_vld = 1'b0; bit_in = i[0];
            @(posedge clk);
            #1;
            chk(byte_vld == 1'b0 && sync_pulse == 1'b0, "R5", "idle cycle quiet",
                {byte_vld, sync_pulse}, 0);
        end
    endtask

    // 8 zeros then the full sync word; expects acquisition on the last bit
    task automatic acquire_lock(input bit with_idle);
        push_byte(8'h00);
        for (int i = 0; i < 31; i++) begin
            push(PRE[i]);
            if (with_idle) idle(1);
        end
        chk(locked == 1'b0, "R2", "not locked before last bit", locked, 0);
        push(PRE[31]);
        chk(sync_pulse == 1'b1 && locked == 1'b1, "R2", "sync and lock on match",
            {sync_pulse, locked}, 3);
        ref_locked = 1'b1; ref_cnt = 0; ref_sr = '0;
    endtask

    task automatic t_reset();
        do_reset();
    endtask

    task automatic t_lock_and_frame();
        do_reset();
        acquire_lock(1'b0);
        push_byte(8'h3C);   // first push also checks the sync pulse has ended (R2)
        push_byte(8'hE1);
        push_byte(8'h00);
    endtask

    task automatic t_idle();
        do_reset();
        acquire_lock(1'b1);
        for (int i = 0; i < 8; i++) begin
            push(8'h96 >> i);
            idle(2);
        end
    endtask

    task automatic t_relock_ignored();
        do_reset();
        acquire_lock(1'b0);
        push(1'b1); push(1'b0); push(1'b1);
        for (int i = 0; i < 32; i++) push(PRE[i]);
        for (int i = 0; i < 13; i++) push(i[0]);
    endtask

    task automatic t_drop();
        do_reset();
        acquire_lock(1'b0);
        for (int i = 0; i < 7; i++) push(1'b1);
        @(negedge clk);
        bit_vld = 1'b1; bit_in = 1'b1; drop_lock = 1'b1;
        @(posedge clk);
        #1;
        chk(locked == 1'b0 && byte_vld == 1'b0, "R7", "drop releases, bit not framed",
            {locked, byte_vld}, 0);
        @(negedge clk);
        bit_vld = 1'b0; drop_lock = 1'b0;
        ref_locked = 1'b0;
        push_byte(8'hFF);
        push_byte(8'h00);
        for (int i = 0; i < 31; i++) push(PRE[i]);
        @(negedge clk);
        bit_vld = 1'b1; bit_in = PRE[31]; drop_lock = 1'b1;
        @(posedge clk);
        #1;
        chk(sync_pulse == 1'b1 && locked == 1'b1, "R7", "drop ignored while searching",
            {sync_pulse, locked}, 3);
        @(negedge clk);
        bit_vld = 1'b0; drop_lock = 1'b0;
        ref_locked = 1'b1; ref_cnt = 0; ref_sr = '0;
        push_byte(8'h5A);
    endtask

    task automatic t_tolerance();
        do_reset();
        for (int i = 0; i < 32; i++) push(PRE[i] ^ (i == 5));
        chk(locked == 1'b0, "R3", "strict rejects one flip", locked, 0);
        chk(locked_t == 1'b1 && sync_t == 1'b1, "R3", "tolerant accepts one flip",
            {locked_t, sync_t}, 3);
        do_reset();
        for (int i = 0; i < 32; i++) push(PRE[i] ^ (i == 5) ^ (i == 20));
        chk(locked_t == 1'b0, "R3", "tolerant rejects two flips", locked_t, 0);
        chk(locked == 1'b0, "R3", "strict rejects two flips", locked, 0);
    endtask

    initial begin
        t_reset();
        t_lock_and_frame();
        t_idle();
        t_relock_ignored();
        t_drop();
        t_tolerance();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule